// File: doc/BRIEF.md
# Folded Four-Lane Polar Encoder (16-bit codeword)

This block encodes 16-bit polar codewords. A message of sixteen bits comes in as four beats of four bits. Frozen positions are already zero at the input. Four coded bits go out per clock. The encoder does not build the full four-stage XOR butterfly. The two butterfly stages that stay inside a beat are built as plain logic. The two stages that span beats are folded onto a shared kernel unit and a twelve-bit bank of delay registers. Each register is reused at a fixed point in the codeword, so none is left idle.

An upstream buffer streams messages in natural index order and marks the first beat of each codeword. Codewords may follow each other with no gap, and idle cycles may appear anywhere. The coded beats for a codeword start one cycle after its fourth beat is accepted. They run for four cycles in a row, in an order where pairs of coded bits are sent bit-reversed.

Top module: `polar_fold_enc`

## Requirements
- R1: A clock edge with `rst_n` low clears `out_valid`, `out_sob` and `out_data` to zero, abandons any partially received or partially emitted codeword, and sets the input beat position to zero.
- R2: Beat k of a codeword (k = 0..3, counted over accepted beats) carries message bit u[4k+i] on `in_data[i]`. A beat is accepted on an edge where `in_valid` is high. The fourth accepted beat completes the codeword.
- R3: The coded word satisfies x[j] = XOR of u[i] over every i whose binary index has all bits of j set (i AND j == j). This equals the product of u with the four-fold Kronecker power of the kernel [[1,0],[1,1]].
- R4: Output beat g (g = 0..3) carries coded pairs p = rev3(2g) and q = rev3(2g+1), where rev3 reverses a 3-bit pair index. The bit layout is `out_data` = {x[2q+1], x[2q], x[2p+1], x[2p]}. The beats are therefore {x9,x8,x1,x0}, {x13,x12,x5,x4}, {x11,x10,x3,x2} and {x15,x14,x7,x6}.
- R5: The first output beat appears in the cycle after the edge that accepts the fourth input beat, with `out_sob` high. The other three beats follow on the next three cycles with `out_sob` low, whatever the input does.
- R6: When no coded beat is being emitted, `out_valid` and `out_sob` are low and `out_data` is zero.
- R7: Cycles with `in_valid` low are skipped and may appear between any two beats of a codeword without changing the result.
- R8: A beat accepted with `in_sob` high is taken as beat 0. Any partially received codeword is discarded.
- R9: A new codeword may start on the cycle right after the previous one's fourth beat, and so on indefinitely. Every codeword is still emitted intact and in order.
- R10: `in_sob` has no effect on a cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_sob | input | 1 | Marks beat 0 of a codeword |
| in_data | input | 4 | Four message bits, natural order |
| out_valid | output | 1 | Coded beat present |
| out_sob | output | 1 | Marks the first coded beat of a codeword |
| out_data | output | 4 | Four coded bits, pairwise bit-reversed order |

## Verification
The all-zero and all-one messages test the polarity and the single surviving bit x15. Each of the sixteen single-one messages sets a chosen set of output bits, so together they expose any wrong generator row or misplaced output lane. Random messages are sent in three ways: with idle cycles and stray start markers inside the codeword, back to back with no gap, and after an aborted partial codeword. These cases separate errors in register reuse and phase tracking from errors in the arithmetic. A reset in the middle of the output burst checks that pending beats are dropped.

// File: rtl/polar_fold_pkg.sv
// Shared constants and types for the folded polar encoder.
// Assumes a 16-bit codeword carried on a 4-bit beat; the slot
// allocation in the fold core is laid out for exactly four beats.
package polar_fold_pkg;
    localparam int CODE_LEN = 16;
    localparam int BEAT_W   = 4;
    localparam int BEATS    = CODE_LEN / BEAT_W;
    localparam int BEAT_LG  = $clog2(BEAT_W);
    localparam int PH_W     = $clog2(BEATS);
    localparam int HALF     = BEAT_W / 2;

    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [PH_W-1:0]   phase_t;

    localparam phase_t PH_FIRST = phase_t'(0);
    localparam phase_t PH_PAIR  = phase_t'(1);
    localparam phase_t PH_THIRD = phase_t'(2);
    localparam phase_t PH_LAST  = phase_t'(BEATS - 1);
endpackage

// File: rtl/pfe_kernel.sv
// Polar kernel unit: maps each lane pair (a, b) to (a^b, b).
// Assumes nothing about timing; purely combinational, W lanes wide.
module pfe_kernel #(
    parameter int W = 2
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] top_o,
    output logic [W-1:0] bot_o
);
    // kernel: upper output carries the sum, lower passes through
    assign top_o = a_i ^ b_i;
    assign bot_o = b_i;
endmodule

// File: rtl/pfe_beat_xform.sv
// In-beat butterfly stages: applies the polar transform of size BEAT_W
// to one beat. Each stage uses BEAT_W/2 kernel units on alternating
// pairs. No storage; these stages need no delay elements.
module pfe_beat_xform
    import polar_fold_pkg::*;
(
    input  beat_t raw_i,
    output beat_t mixed_o
);
    logic [BEAT_LG:0][BEAT_W-1:0] lvl;

    assign lvl[0]  = raw_i;
    assign mixed_o = lvl[BEAT_LG];

    // one row of kernel units per in-beat stage
    for (genvar s = 0; s < BEAT_LG; s++) begin : g_stage
        localparam int SPAN = 1 << s;
        for (genvar k = 0; k < BEAT_W / 2; k++) begin : g_unit
            localparam int LO = ((k >> s) << (s + 1)) | (k & (SPAN - 1));
            pfe_kernel #(.W(1)) u_kern (
                .a_i  (lvl[s][LO]),
                .b_i  (lvl[s][LO + SPAN]),
                .top_o(lvl[s + 1][LO]),
                .bot_o(lvl[s + 1][LO + SPAN])
            );
        end
    end
endmodule

// File: rtl/pfe_fold_core.sv
// Cross-beat stages of the encoder, folded onto one shared kernel for
// the span-4 stage and two kernels for the span-8 stage, with twelve
// delay registers in three 4-bit slots whose contents change with the
// beat position. Assumes slot reads for the output drain happen in the
// same cycle as, or before, the overwrite by the next codeword.
module pfe_fold_core
    import polar_fold_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   take_i,
    input  phase_t phase_i,
    input  beat_t  beat_i,
    output beat_t  head_o,
    output beat_t  slot_a_o,
    output beat_t  slot_b_o,
    output beat_t  slot_c_o
);
    beat_t slot_a, slot_b, slot_c;
    beat_t s3_hi, s3_top, s3_bot;
    beat_t fa_top, fa_bot, fb_top, fb_bot;
    beat_t grp1, grp2, grp3;

    // operand select: beat 1 pairs with beat 0, beat 3 pairs with beat 2
    always_comb s3_hi = (phase_i == PH_PAIR) ? slot_a : slot_c;

    pfe_kernel #(.W(BEAT_W)) u_s3 (
        .a_i(s3_hi), .b_i(beat_i), .top_o(s3_top), .bot_o(s3_bot)
    );

    // span-8 units: lower half words from slots, upper half from this beat
    pfe_kernel #(.W(BEAT_W)) u_s4a (
        .a_i(slot_a), .b_i(s3_top), .top_o(fa_top), .bot_o(fa_bot)
    );
    pfe_kernel #(.W(BEAT_W)) u_s4b (
        .a_i(slot_b), .b_i(s3_bot), .top_o(fb_top), .bot_o(fb_bot)
    );

    // gather coded pairs into output beats in pair-reversed order
    always_comb begin
        head_o = {fa_bot[HALF-1:0],      fa_top[HALF-1:0]};
        grp1   = {fb_bot[HALF-1:0],      fb_top[HALF-1:0]};
        grp2   = {fa_bot[BEAT_W-1:HALF], fa_top[BEAT_W-1:HALF]};
        grp3   = {fb_bot[BEAT_W-1:HALF], fb_top[BEAT_W-1:HALF]};
    end

    // register allocation: each slot is rewritten at a fixed beat position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_a <= '0;
            slot_b <= '0;
            slot_c <= '0;
        end else if (take_i) begin
            unique case (phase_i)
                PH_FIRST: slot_a <= beat_i;
                PH_PAIR: begin
                    slot_a <= s3_top;
                    slot_b <= s3_bot;
                end
                PH_THIRD: slot_c <= beat_i;
                default: begin
                    slot_a <= grp1;
                    slot_b <= grp2;
                    slot_c <= grp3;
                end
            endcase
        end
    end

    assign slot_a_o = slot_a;
    assign slot_b_o = slot_b;
    assign slot_c_o = slot_c;
endmodule

// File: rtl/polar_fold_enc.sv
// Top of the folded polar encoder. Tracks the beat position of the
// incoming codeword, runs the in-beat and cross-beat stages, and
// sequences the four coded beats out of registered outputs.
// Assumes frozen bits are already zero in the message.
module polar_fold_enc
    import polar_fold_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sob,
    input  logic [BEAT_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_sob,
    output logic [BEAT_W-1:0] out_data
);
    phase_t phase_q, eff_phase, drain_q;
    beat_t  mixed, head, slot_a, slot_b, slot_c;
    logic   last_beat;

    // a start marker forces beat 0; otherwise continue the count
    always_comb begin
        eff_phase = in_sob ? PH_FIRST : phase_q;
        last_beat = in_valid && (eff_phase == PH_LAST);
    end

    // beat position counter, advanced by accepted beats only
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= PH_FIRST;
        else if (in_valid) phase_q <= eff_phase + phase_t'(1);
    end

    pfe_beat_xform u_xform (.raw_i(in_data), .mixed_o(mixed));

    pfe_fold_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (in_valid),
        .phase_i (eff_phase),
        .beat_i  (mixed),
        .head_o  (head),
        .slot_a_o(slot_a),
        .slot_b_o(slot_b),
        .slot_c_o(slot_c)
    );

    // drain counter: 1..3 while the stored beats are being sent
    always_ff @(posedge clk) begin
        if (!rst_n)                drain_q <= '0;
        else if (last_beat)        drain_q <= phase_t'(1);
        else if (drain_q != '0)    drain_q <= drain_q + phase_t'(1);
    end

    // registered output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sob   <= 1'b0;
            out_data  <= '0;
        end else if (last_beat) begin
            out_valid <= 1'b1;
            out_sob   <= 1'b1;
            out_data  <= head;
        end else if (drain_q != '0) begin
            out_valid <= 1'b1;
            out_sob   <= 1'b0;
            unique case (drain_q)
                phase_t'(1): out_data <= slot_a;
                phase_t'(2): out_data <= slot_b;
                default:     out_data <= slot_c;
            endcase
        end else begin
            out_valid <= 1'b0;
            out_sob   <= 1'b0;
            out_data  <= '0;
        end
    end
endmodule

// File: rtl/polar_fold_enc_chk.sv
// Protocol checker for polar_fold_enc: relates accepted input beats to
// output bursts. Bound to the top module below.
module polar_fold_enc_chk
    import polar_fold_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sob,
    input logic              out_valid,
    input logic              out_sob,
    input logic [BEAT_W-1:0] out_data
);
    phase_t acc_cnt, burst_cnt;
    logic   fourth;

    // independent view of which accepted beat closes a codeword
    always_comb fourth = in_valid && ((in_sob ? PH_FIRST : acc_cnt) == PH_LAST);

    // count accepted beats since the last start marker
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_cnt <= '0;
        else if (in_valid) acc_cnt <= (in_sob ? PH_FIRST : acc_cnt) + phase_t'(1);
    end

    // position inside the current output burst
    always_ff @(posedge clk) begin
        if (!rst_n)               burst_cnt <= '0;
        else if (out_sob)         burst_cnt <= phase_t'(1);
        else if (burst_cnt != '0) burst_cnt <= burst_cnt + phase_t'(1);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!out_valid && !out_sob && out_data == '0)); // R1
    AST_SOB_AFTER_FOURTH: assert property (@(posedge clk) disable iff (!rst_n) fourth |=> out_sob); // R5
    AST_SOB_NEEDS_FOURTH: assert property (@(posedge clk) disable iff (!rst_n) out_sob |-> $past(fourth)); // R2
    AST_SOB_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_sob |-> out_valid); // R5
    AST_BURST_BODY: assert property (@(posedge clk) disable iff (!rst_n) (burst_cnt != '0) |-> (out_valid && !out_sob)); // R5
    AST_NO_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (out_valid && !out_sob) |-> (burst_cnt != '0)); // R6
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !out_valid |-> (out_data == '0 && !out_sob)); // R6
endmodule

bind polar_fold_enc polar_fold_enc_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sob   (in_sob),
    .out_valid(out_valid),
    .out_sob  (out_sob),
    .out_data (out_data)
);

// File: tb/polar_fold_enc_tb_top.sv
// Bench for polar_fold_enc: drives codewords through a behavioural
// model (generator-matrix product plus output queue) and compares the
// outputs after every clock edge.
module polar_fold_enc_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sob = 1'b0;
    logic [3:0] in_data = '0;
    logic       out_valid, out_sob;
    logic [3:0] out_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [15:0] m_u = '0;
    int          m_phase = 0;
    logic [3:0]  m_pend[$];

    always #4 clk = ~clk;

    polar_fold_enc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sob(in_sob),
        .in_data(in_data), .out_valid(out_valid), .out_sob(out_sob),
        .out_data(out_data)
    );

    // x[j] = XOR of u[i] over all i containing j (R3)
    function automatic logic [15:0] encode(input logic [15:0] u);
        logic [15:0] x;
        for (int j = 0; j < 16; j++) begin
            x[j] = 1'b0;
            for (int i = 0; i < 16; i++)
                if ((i & j) == j) x[j] = x[j] ^ u[i];
        end
        return x;
    endfunction

    function automatic int rev3(input int k);
        return ((k & 1) << 2) | (k & 2) | ((k >> 2) & 1);
    endfunction

    // output beat g per R4
    function automatic logic [3:0] grp(input logic [15:0] x, input int g);
        int p, q;
        p = rev3(2 * g);
        q = rev3(2 * g + 1);
        return {x[2*q+1], x[2*q], x[2*p+1], x[2*p]};
    endfunction

    task automatic tick(input string tag, input logic v, input logic s, input logic [3:0] d);
        logic ev, es;
        logic [3:0] ed;
        logic [15:0] x;
        int eff;
        in_valid = v;
        in_sob   = s;
        in_data  = d;
        @(posedge clk);
        #2;
        ev = 1'b0; es = 1'b0; ed = '0;
        if (!rst_n) begin
            m_phase = 0;
            m_pend.delete();
        end else begin
            eff = s ? 0 : m_phase;
            if (v) m_u[4*eff +: 4] = d;
            if (v && eff == 3) begin
                x = encode(m_u);
                ev = 1'b1; es = 1'b1; ed = grp(x, 0);
                m_pend.delete();
                for (int g = 1; g < 4; g++) m_pend.push_back(grp(x, g));
            end else if (m_pend.size() > 0) begin
                ev = 1'b1;
                ed = m_pend.pop_front();
            end
            if (v) m_phase = (eff + 1) % 4;
        end
        n_chk++;
        if ({out_valid, out_sob, out_data} !== {ev, es, ed}) begin
            n_fail++;
            $display("FAIL %s [%s]: got valid=%0b sob=%0b data=%h, expected valid=%0b sob=%0b data=%h",
                     tag, ev ? (es ? "R5 first beat" : "R4 order") : "R6 idle",
                     out_valid, out_sob, out_data, ev, es, ed);
        end
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 1'b0, 1'($urandom), 4'($urandom));
    endtask

    // one codeword; inner idle cycles between beats, outer after
    task automatic send_cw(input string tag, input logic [15:0] u, input int inner, input int outer);
        for (int b = 0; b < 4; b++) begin
            if (b > 0) idle(tag, inner);
            tick(tag, 1'b1, b == 0, u[4*b +: 4]);
        end
        for (int i = 0; i < outer; i++) tick(tag, 1'b0, 1'b0, 4'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got no completion, expected end of stimulus");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle during and after reset
        for (int i = 0; i < 3; i++) tick("R1 in reset", 1'b0, 1'b0, 4'h0);
        rst_n = 1'b1;
        for (int i = 0; i < 2; i++) tick("R1 after reset", 1'b0, 1'b0, 4'h0);

        // R3: fixed patterns and every generator row, back to back
        send_cw("R3 all-zero", 16'h0000, 0, 0);
        send_cw("R3 all-one", 16'hFFFF, 0, 0);
        for (int i = 0; i < 16; i++) send_cw("R3 single-one", 16'(1 << i), 0, 0);
        idle("R6 drain", 4);

        // R2: isolated random codewords
        for (int k = 0; k < 6; k++) send_cw("R2 random", 16'($urandom), 0, 3);

        // R7 and R10: idle cycles with stray markers inside codewords
        for (int k = 0; k < 6; k++) send_cw("R7 inner gaps", 16'($urandom), 1 + k % 3, 2);
        for (int k = 0; k < 4; k++) send_cw("R10 idle marker", 16'($urandom), 2, 0);
        idle("R10 drain", 4);

        // R8: partial codewords abandoned by a new start marker
        tick("R8 partial", 1'b1, 1'b1, 4'($urandom));
        tick("R8 partial", 1'b1, 1'b0, 4'($urandom));
        send_cw("R8 restart", 16'($urandom), 0, 0);
        tick("R8 partial", 1'b1, 1'b1, 4'($urandom));
        tick("R8 partial", 1'b1, 1'b0, 4'($urandom));
        tick("R8 partial", 1'b1, 1'b0, 4'($urandom));
        send_cw("R8 restart", 16'($urandom), 0, 5);

        // R9: long back-to-back stream
        for (int k = 0; k < 24; k++) send_cw("R9 back-to-back", 16'($urandom), 0, 0);
        idle("R9 drain", 5);

        // R1: reset in the middle of an output burst
        send_cw("R1 pre-reset", 16'($urandom), 0, 1);
        rst_n = 1'b0;
        tick("R1 mid-burst reset", 1'b0, 1'b0, 4'h0);
        rst_n = 1'b1;
        idle("R1 after reset", 4);
        send_cw("R1 resume", 16'($urandom), 0, 5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule